// File: doc/BRIEF.md
# Element Saturation Clamp Unit

This block takes one integer element result and limits it to the range of a destination element width. The result arrives already computed at the larger of the source and destination widths. It is a signed value two bits wider than the widest element, so a full-width unsigned result and a full-width signed result can both be represented. When saturation is enabled, the unit clamps the value to the unsigned range or to the signed range of the chosen width. It then registers the clamped value, zero-extended above that width, together with an overflow flag for the condition field of that element.

The overflow flag depends only on the element being processed. No summary bit is read or written, and nothing carries over from one element to the next. If saturation is requested together with overflow-enable, the unit raises an illegal-instruction indication. While saturation is active, the carry outputs have no architectural meaning and are driven to zero. With saturation off, the unit truncates the value to the destination width and passes the carries through unchanged.

Top module: `sat_clamp_unit`

## Requirements
- R1: With saturation on, signed mode 0 and a value above 2^w-1 (w = destination width), the output is 2^w-1 and the overflow flag is 1.
- R2: With saturation on, signed mode 0 and a negative value, the output is 0 and the overflow flag is 1.
- R3: With saturation on and signed mode 1, a value above 2^(w-1)-1 gives 2^(w-1)-1, and a value below -2^(w-1) gives the w-bit pattern of -2^(w-1) (a 1 in bit w-1 and zeros below it). The overflow flag is 1 in both cases.
- R4: A value that lies inside the selected range comes out as its low w bits with overflow 0. The flag is not sticky: an in-range element that follows an overflowing one shows 0.
- R5: The width select codes are 00=64, 01=32, 10=16 and 11=8 bits. Output bits at position w and above are always 0.
- R6: With saturation off, the output is the input truncated to w bits, the overflow flag is 0, and both carry outputs equal the carry inputs.
- R7: With saturation on and no illegal combination, both carry outputs are 0.
- R8: Saturation on with overflow-enable 1 sets the illegal flag and forces the result, the overflow flag and the carries to 0. Overflow-enable with saturation off has no effect, and the illegal flag stays 0.
- R9: Results appear one clock after the input is valid, with out_valid high in that cycle. While in_valid is low, every result output holds its value.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Element present on the inputs |
| res_in | input | 66 | Wide signed element result |
| ew_sel | input | 2 | Destination width select |
| sat_signed | input | 1 | 0 = unsigned clamp, 1 = signed clamp |
| sat_en | input | 1 | Saturation requested |
| oe_in | input | 1 | Overflow-enable of the operation |
| ca_in | input | 1 | Carry of the operation |
| ca32_in | input | 1 | 32-bit carry of the operation |
| out_valid | output | 1 | Registered result valid |
| res_out | output | 64 | Clamped result, zero-extended |
| ovf_out | output | 1 | Element overflow flag |
| illegal_out | output | 1 | Illegal mode combination |
| ca_out | output | 1 | Carry, forced to 0 under saturation |
| ca32_out | output | 1 | 32-bit carry, forced to 0 under saturation |

## Verification
The only state in this block is a single output register stage, so any wrong internal value shows up at the ports on the very next clock. A wrong bound for one width shows as a wrong value at exactly the width code where it belongs. An off-by-one comparison shows only at the boundary values, such as 255 against 256 or -128 against -129, so those values are driven for several widths. An overflow flag that stuck, or a result that moved during an idle cycle, would be visible in the cycle after the element that follows.

// File: rtl/sat_pkg.sv
package sat_pkg;

  typedef enum logic [1:0] {
    EW_FULL    = 2'b00,
    EW_HALF    = 2'b01,
    EW_QUARTER = 2'b10,
    EW_EIGHTH  = 2'b11
  } ew_sel_e;

  typedef struct packed {
    logic ovf;
    logic illegal;
    logic ca;
    logic ca32;
  } sat_flags_t;

  // Element width in bits for a given select code.
  function automatic int unsigned ew_bits(input int unsigned full_w, input int unsigned code);
    return full_w >> code;
  endfunction

endpackage

// File: rtl/sat_bounds.sv
module sat_bounds #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IN_W   = DATA_W + 2
) (
  input  logic [1:0]               ew_sel,
  output logic signed [IN_W-1:0]   u_max,
  output logic signed [IN_W-1:0]   s_max,
  output logic signed [IN_W-1:0]   s_min,
  output logic [DATA_W-1:0]        keep_mask
);
  localparam int unsigned NSEL = 4;
  localparam logic [IN_W-1:0] ONE = IN_W'(1);

  logic signed [IN_W-1:0] umax_a [NSEL];
  logic signed [IN_W-1:0] smax_a [NSEL];
  logic signed [IN_W-1:0] smin_a [NSEL];
  logic [DATA_W-1:0]      mask_a [NSEL];

  for (genvar g = 0; g < NSEL; g++) begin : g_width
    localparam int unsigned W = sat_pkg::ew_bits(DATA_W, g);
    localparam logic [IN_W-1:0] UMAX = (ONE << W) - ONE;
    localparam logic [IN_W-1:0] SMAX = (ONE << (W - 1)) - ONE;
    assign umax_a[g] = $signed(UMAX);
    assign smax_a[g] = $signed(SMAX);
    assign smin_a[g] = $signed(~SMAX);
    assign mask_a[g] = UMAX[DATA_W-1:0];
  end

  assign u_max     = umax_a[ew_sel];
  assign s_max     = smax_a[ew_sel];
  assign s_min     = smin_a[ew_sel];
  assign keep_mask = mask_a[ew_sel];

endmodule

// File: rtl/sat_core.sv
module sat_core
  import sat_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IN_W   = DATA_W + 2
) (
  input  logic signed [IN_W-1:0] x,
  input  logic signed [IN_W-1:0] u_max,
  input  logic signed [IN_W-1:0] s_max,
  input  logic signed [IN_W-1:0] s_min,
  input  logic [DATA_W-1:0]      keep_mask,
  input  logic                   signed_mode,
  input  logic                   sat_en,
  input  logic                   oe,
  input  logic                   ca_in,
  input  logic                   ca32_in,
  output logic [DATA_W-1:0]      y,
  output sat_flags_t             flags,
  output logic                   clamp_hi,
  output logic                   clamp_lo
);
  logic signed [IN_W-1:0] hi_b;
  logic signed [IN_W-1:0] lo_b;
  logic                   bad_combo;

  assign hi_b      = signed_mode ? s_max : u_max;
  assign lo_b      = signed_mode ? s_min : '0;
  assign bad_combo = sat_en & oe;
  assign clamp_hi  = sat_en & ~bad_combo & (x > hi_b);
  assign clamp_lo  = sat_en & ~bad_combo & (x < lo_b);

  always_comb begin
    y             = x[DATA_W-1:0] & keep_mask;
    flags.ovf     = 1'b0;
    flags.illegal = 1'b0;
    flags.ca      = ca_in;
    flags.ca32    = ca32_in;
    if (bad_combo) begin
      y             = '0;
      flags.illegal = 1'b1;
      flags.ca      = 1'b0;
      flags.ca32    = 1'b0;
    end else if (sat_en) begin
      flags.ca   = 1'b0;
      flags.ca32 = 1'b0;
      if (clamp_hi) begin
        y         = hi_b[DATA_W-1:0] & keep_mask;
        flags.ovf = 1'b1;
      end else if (clamp_lo) begin
        y         = lo_b[DATA_W-1:0] & keep_mask;
        flags.ovf = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sat_clamp_unit.sv
module sat_clamp_unit
  import sat_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [DATA_W+1:0]     res_in,
  input  logic [1:0]            ew_sel,
  input  logic                  sat_signed,
  input  logic                  sat_en,
  input  logic                  oe_in,
  input  logic                  ca_in,
  input  logic                  ca32_in,
  output logic                  out_valid,
  output logic [DATA_W-1:0]     res_out,
  output logic                  ovf_out,
  output logic                  illegal_out,
  output logic                  ca_out,
  output logic                  ca32_out
);
  localparam int unsigned IN_W = DATA_W + 2;

  logic signed [IN_W-1:0] u_max, s_max, s_min;
  logic [DATA_W-1:0]      keep_mask;
  logic [DATA_W-1:0]      y_d;
  sat_flags_t             flags_d;
  logic                   clamp_hi_w;
  logic                   clamp_lo_w;

  sat_bounds #(.DATA_W(DATA_W), .IN_W(IN_W)) u_bounds (
    .ew_sel    (ew_sel),
    .u_max     (u_max),
    .s_max     (s_max),
    .s_min     (s_min),
    .keep_mask (keep_mask)
  );

  sat_core #(.DATA_W(DATA_W), .IN_W(IN_W)) u_core (
    .x           ($signed(res_in)),
    .u_max       (u_max),
    .s_max       (s_max),
    .s_min       (s_min),
    .keep_mask   (keep_mask),
    .signed_mode (sat_signed),
    .sat_en      (sat_en),
    .oe          (oe_in),
    .ca_in       (ca_in),
    .ca32_in     (ca32_in),
    .y           (y_d),
    .flags       (flags_d),
    .clamp_hi    (clamp_hi_w),
    .clamp_lo    (clamp_lo_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      res_out     <= '0;
      ovf_out     <= 1'b0;
      illegal_out <= 1'b0;
      ca_out      <= 1'b0;
      ca32_out    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_out     <= y_d;
        ovf_out     <= flags_d.ovf;
        illegal_out <= flags_d.illegal;
        ca_out      <= flags_d.ca;
        ca32_out    <= flags_d.ca32;
      end
    end
  end

endmodule

// File: rtl/sat_clamp_unit_chk.sv
module sat_clamp_unit_chk #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W+1:0] res_in,
  input logic [1:0]        ew_sel,
  input logic              sat_signed,
  input logic              sat_en,
  input logic              oe_in,
  input logic              ca_in,
  input logic              out_valid,
  input logic [DATA_W-1:0] res_out,
  input logic              ovf_out,
  input logic              illegal_out,
  input logic              ca_out,
  input logic              ca32_out,
  input logic              clamp_hi_w,
  input logic              clamp_lo_w
);
  localparam int unsigned Q = DATA_W >> 3;

  p_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(res_out) && $stable(ovf_out) && $stable(illegal_out)));
  p_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sat_en && oe_in) |=> (illegal_out && res_out == '0 && !ovf_out));
  p_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(sat_en && oe_in)) |=> !illegal_out);
  p_carry_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sat_en) |=> (!ca_out && !ca32_out));
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sat_en) |=> !ovf_out);
  p_carry_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sat_en) |=> (ca_out == $past(ca_in)));
  p_zext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ew_sel == 2'b11) |=> (res_out[DATA_W-1:Q] == '0));
  p_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sat_en && !oe_in && !sat_signed && res_in[DATA_W+1])
      |=> (res_out == '0 && ovf_out));
  p_one_side_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(clamp_hi_w && clamp_lo_w));
  p_flag_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (ovf_out == ($past(clamp_hi_w) || $past(clamp_lo_w))));

endmodule

bind sat_clamp_unit sat_clamp_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .res_in      (res_in),
  .ew_sel      (ew_sel),
  .sat_signed  (sat_signed),
  .sat_en      (sat_en),
  .oe_in       (oe_in),
  .ca_in       (ca_in),
  .out_valid   (out_valid),
  .res_out     (res_out),
  .ovf_out     (ovf_out),
  .illegal_out (illegal_out),
  .ca_out      (ca_out),
  .ca32_out    (ca32_out),
  .clamp_hi_w  (clamp_hi_w),
  .clamp_lo_w  (clamp_lo_w)
);

// File: tb/sat_clamp_unit_tb.sv
`timescale 1ns/1ps
module sat_clamp_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [65:0] res_in = '0;
  logic [1:0] ew_sel = '0;
  logic sat_signed = 1'b0, sat_en = 1'b0, oe_in = 1'b0, ca_in = 1'b0, ca32_in = 1'b0;
  logic out_valid, ovf_out, illegal_out, ca_out, ca32_out;
  logic [63:0] res_out;

  logic [63:0] e_res = '0;
  logic e_v = 1'b0, e_ovf = 1'b0, e_il = 1'b0, e_ca = 1'b0, e_c32 = 1'b0;
  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  sat_clamp_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .res_in(res_in),
    .ew_sel(ew_sel), .sat_signed(sat_signed), .sat_en(sat_en), .oe_in(oe_in),
    .ca_in(ca_in), .ca32_in(ca32_in), .out_valid(out_valid), .res_out(res_out),
    .ovf_out(ovf_out), .illegal_out(illegal_out), .ca_out(ca_out), .ca32_out(ca32_out)
  );

  function automatic void ref_model(
    input logic signed [65:0] x, input logic [1:0] sel,
    input logic n, input logic en, input logic oe, input logic ca, input logic c32,
    output logic [63:0] r, output logic o, output logic il, output logic co, output logic c32o);
    int w;
    logic [63:0] m;
    logic signed [65:0] upper;
    case (sel)
      2'b00: w = 64;
      2'b01: w = 32;
      2'b10: w = 16;
      default: w = 8;
    endcase
    m = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    r = x[63:0] & m; o = 1'b0; il = 1'b0; co = ca; c32o = c32;
    if (en && oe) begin
      r = '0; il = 1'b1; co = 1'b0; c32o = 1'b0;
    end else if (en) begin
      co = 1'b0; c32o = 1'b0;
      if (!n) begin
        if (x < 0) begin r = '0; o = 1'b1; end
        else if ((x >> w) != 0) begin r = m; o = 1'b1; end
      end else begin
        upper = x >>> (w - 1);
        if (upper != 0 && upper != -66'sd1) begin
          o = 1'b1;
          r = (x < 0) ? ((m >> 1) + 64'd1) : (m >> 1);
        end
      end
    end
  endfunction

  task automatic compare(input string tag);
    total++;
    if ({out_valid, res_out, ovf_out, illegal_out, ca_out, ca32_out} !==
        {e_v, e_res, e_ovf, e_il, e_ca, e_c32}) begin
      fails++;
      $display("FAIL %s: actual v=%b res=%h ovf=%b il=%b ca=%b ca32=%b expected v=%b res=%h ovf=%b il=%b ca=%b ca32=%b",
        tag, out_valid, res_out, ovf_out, illegal_out, ca_out, ca32_out,
        e_v, e_res, e_ovf, e_il, e_ca, e_c32);
    end
  endtask

  task automatic step(input logic v, input logic signed [65:0] x, input logic [1:0] sel,
                      input logic n, input logic en, input logic oe,
                      input logic ca, input logic c32, input string tag);
    @(negedge clk);
    in_valid = v; res_in = x; ew_sel = sel; sat_signed = n; sat_en = en;
    oe_in = oe; ca_in = ca; ca32_in = c32;
    e_v = v;
    if (v) ref_model(x, sel, n, en, oe, ca, c32, e_res, e_ovf, e_il, e_ca, e_c32);
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  initial begin
    #800000;
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic signed [65:0] big;
    repeat (3) @(posedge clk);
    #1;
    compare("R10 reset");
    @(negedge clk);
    rst_n = 1'b1;
    // R4 in range, unsigned 8
    step(1, 66'sd200, 2'b11, 0, 1, 0, 1, 1, "R4 u8 in range");
    step(1, 66'sd255, 2'b11, 0, 1, 0, 0, 0, "R4 u8 max edge");
    // R1 unsigned high
    step(1, 66'sd256, 2'b11, 0, 1, 0, 0, 0, "R1 u8 256");
    step(1, 66'sd70000, 2'b10, 0, 1, 0, 0, 0, "R1 u16 high");
    big = 66'sd1 <<< 64;
    step(1, big, 2'b00, 0, 1, 0, 0, 0, "R1 u64 2^64");
    step(1, big - 66'sd1, 2'b00, 0, 1, 0, 0, 0, "R4 u64 max edge");
    // R4 non-sticky
    step(1, 66'sd300, 2'b11, 0, 1, 0, 0, 0, "R1 u8 300");
    step(1, 66'sd3, 2'b11, 0, 1, 0, 0, 0, "R4 non-sticky");
    // R2 unsigned negative
    step(1, -66'sd5, 2'b10, 0, 1, 0, 0, 0, "R2 u16 negative");
    step(1, -66'sd1, 2'b00, 0, 1, 0, 1, 0, "R2 u64 negative");
    // R3 signed
    step(1, 66'sd127, 2'b11, 1, 1, 0, 0, 0, "R4 s8 max edge");
    step(1, 66'sd128, 2'b11, 1, 1, 0, 0, 0, "R3 s8 128");
    step(1, -66'sd128, 2'b11, 1, 1, 0, 0, 0, "R4 s8 min edge");
    step(1, -66'sd129, 2'b11, 1, 1, 0, 0, 0, "R3 s8 -129");
    step(1, 66'sd1 <<< 63, 2'b00, 1, 1, 0, 0, 0, "R3 s64 2^63");
    step(1, -(66'sd1 <<< 40), 2'b01, 1, 1, 0, 0, 0, "R3 s32 low");
    step(1, 66'sd40000, 2'b10, 1, 1, 0, 0, 0, "R3 s16 high");
    step(1, -66'sd2, 2'b01, 1, 1, 0, 0, 0, "R5 s32 zero-extend");
    // R5 widths
    step(1, 66'sh1_2345_6789, 2'b01, 0, 1, 0, 0, 0, "R5 u32 clamp");
    step(1, 66'sh1234, 2'b01, 0, 1, 0, 0, 0, "R5 u32 in range");
    // R6 saturation off
    step(1, 66'sh1234, 2'b11, 0, 0, 0, 1, 0, "R6 truncate 8");
    step(1, -66'sd3, 2'b10, 1, 0, 0, 0, 1, "R6 truncate 16");
    step(1, 66'sh3_0000_0000_0000_00AB, 2'b00, 0, 0, 0, 1, 1, "R6 truncate 64");
    // R7 carries under saturation
    step(1, 66'sd9, 2'b11, 0, 1, 0, 1, 1, "R7 carries zero");
    // R8 illegal
    step(1, 66'sd999, 2'b11, 0, 1, 1, 1, 1, "R8 sat with oe");
    step(1, 66'sd5, 2'b11, 1, 1, 1, 0, 1, "R8 signed sat with oe");
    step(1, 66'sd999, 2'b11, 0, 0, 1, 1, 0, "R8 oe alone");
    // R9 hold while idle
    step(1, 66'sd500, 2'b11, 0, 1, 0, 0, 0, "R9 load");
    step(0, 66'sd1, 2'b00, 1, 0, 1, 1, 1, "R9 idle hold");
    step(0, -66'sd7, 2'b10, 0, 1, 1, 0, 0, "R9 idle hold 2");
    step(1, 66'sd7, 2'b10, 0, 1, 0, 0, 0, "R9 resume");
    step(0, 66'sd0, 2'b00, 0, 0, 0, 0, 0, "R9 valid drop");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule